// File: doc/BRIEF.md
# Tag-Pair Store Execute Unit

This unit runs the execute step of one 32-bit instruction word that writes a single 4-bit memory tag to two adjacent 16-byte granules. It checks the word against the one encoding it accepts and reads the base register and the tag source register through a combinational register-read port. It then forms a granule-scaled signed offset and presents two tag writes, one after the other, on a valid/ready tag-write port. When the addressing form calls for it, the unit returns the updated base address on a one-cycle writeback strobe.

The unit takes one instruction at a time. An instruction is accepted when `instrValid` and `instrReady` are both high at a clock edge. While the unit is idle, the register indices come straight from the word that is offered, so the register data must be valid in the same cycle. A word that does not decode, or that arrives while the feature is switched off, ends with a one-cycle undefined flag. A stack-pointer base whose low four bits are not zero ends with a one-cycle alignment-fault flag. In both cases the unit makes no tag write and no writeback.

Top module: `tagpair_store`

## Requirements
- R1: A word is legal only when bits [31:24] equal 8'hD9, bits [23:22] equal 2'b10, bit 21 is 1 and the form field (bits [11:10]) is not 2'b00. Any other word raises `undefFlag` for exactly the one cycle after acceptance, with no tag write and no writeback.
- R2: When `featureEn` is low at acceptance, even a legal word raises `undefFlag`, and no tag write or writeback follows.
- R3: The byte offset is the 9-bit field in bits [20:12], sign-extended to 64 bits and shifted left by 4. The range runs from -4096 to +4080.
- R4: Form field 2'b10 (plain offset) and 2'b11 (pre-index) place the first tag write at base+offset. Form field 2'b01 (post-index) places it at the unmodified base.
- R5: The second tag write goes to the first address plus 16, always after the first one. Both writes carry the same tag.
- R6: The tag is bits [59:56] of the source register named by bits [4:0]. The base register is named by bits [9:5]. Index 31 is passed to the register port unchanged and names the stack pointer.
- R7: When the base index is 31 and the base value has a nonzero low nibble, `alignFault` pulses for one cycle, and no tag write or writeback occurs.
- R8: Forms 2'b01 and 2'b11 assert `wbValid` for exactly one cycle, after both tag writes have been accepted, with `wbIdx` equal to the base index and `wbData` equal to base+offset. Form 2'b10 makes no writeback.
- R9: While `tagValid` is high and `tagReady` is low, `tagAddr` and `tagData` hold steady. Each write completes only on a cycle where both are high.
- R10: After reset the unit is idle: `instrReady` is high and `tagValid`, `wbValid`, `undefFlag` and `alignFault` are low. `instrReady` is high only when no tag write or writeback is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| featureEn | input | 1 | Memory-tagging feature enable |
| instrValid | input | 1 | Instruction word offered |
| instrWord | input | 32 | Instruction word |
| instrReady | output | 1 | Unit idle; the word is taken at this edge |
| rfBaseIdx | output | 5 | Base register index (31 = stack pointer) |
| rfBaseData | input | 64 | Base register value |
| rfSrcIdx | output | 5 | Tag source register index (31 = stack pointer) |
| rfSrcData | input | 64 | Tag source register value |
| tagValid | output | 1 | Tag write request |
| tagReady | input | 1 | Tag write accepted |
| tagAddr | output | 64 | Granule address of the tag write |
| tagData | output | 4 | Tag value |
| wbValid | output | 1 | Base register writeback strobe |
| wbIdx | output | 5 | Writeback register index |
| wbData | output | 64 | Updated base address |
| undefFlag | output | 1 | Undefined-instruction pulse |
| alignFault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The bench aims at the places where the address arithmetic is easy to get wrong. The most negative and most positive offsets show whether the sign extension or the shift by four is missing, and a base close to 2^64 shows whether the address wraps properly. Post-index words set against pre-index words with the same operands expose a swapped form decode: such a design would write tags at base+offset when it should use the bare base, or the other way round. Random stalls on `tagReady` and checks that writeback never comes before the second accepted write catch an early or missing strobe. Stack-pointer bases with a bad low nibble, form 2'b00, single corrupted header bits and a switched-off feature must each end with the right flag and no memory traffic. A design that fails here would either write tags it should drop or stay silent on a legal word.

// File: rtl/tagpair_pkg.sv
package tagpair_pkg;

  localparam logic [7:0] HDR_MAJOR = 8'hD9;
  localparam logic [1:0] HDR_OPC   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_WB     = 2'd3
  } state_e;

  typedef struct packed {
    logic capture;
    logic useSecond;
  } dpStrobe_t;

endpackage

// File: rtl/tagpair_decode.sv
module tagpair_decode #(
  parameter int ADDR_W       = 64,
  parameter int GRANULE_LOG2 = 4,
  parameter int REG_IDX_W    = 5
) (
  input  logic [31:0]          instrWord,
  input  logic                 featureEn,
  output logic                 legal,
  output logic                 writeBack,
  output logic                 postIndex,
  output logic [REG_IDX_W-1:0] baseIdx,
  output logic [REG_IDX_W-1:0] srcIdx,
  output logic [ADDR_W-1:0]    offset
);
  import tagpair_pkg::*;

  localparam int IMM_W = 9;

  logic [1:0]       formSel;
  logic [IMM_W-1:0] immField;
  logic             headerOk;

  always_comb begin
    formSel  = instrWord[11:10];
    immField = instrWord[20:12];
    headerOk = (instrWord[31:24] == HDR_MAJOR) &&
               (instrWord[23:22] == HDR_OPC) && instrWord[21];
    legal     = featureEn && headerOk && (formSel != 2'b00);
    writeBack = formSel[0];
    postIndex = (formSel == 2'b01);
    baseIdx   = instrWord[9:5];
    srcIdx    = instrWord[4:0];
    offset    = {{(ADDR_W-IMM_W){immField[IMM_W-1]}}, immField} << GRANULE_LOG2;
  end

endmodule

// File: rtl/tagpair_ctrl.sv
module tagpair_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instrValid,
  input  logic                   legal,
  input  logic                   spMisaligned,
  input  logic                   wbPending,
  input  logic                   tagReady,
  output logic                   instrReady,
  output logic                   tagValid,
  output logic                   wbValid,
  output logic                   undefFlag,
  output logic                   alignFault,
  output tagpair_pkg::dpStrobe_t strobe
);
  import tagpair_pkg::*;

  state_e stateR, stateNext;
  logic   accept;
  logic   undefR, alignR;

  always_comb begin
    accept           = instrValid && (stateR == ST_IDLE);
    strobe.capture   = accept && legal && !spMisaligned;
    strobe.useSecond = (stateR == ST_SECOND);
    stateNext        = stateR;
    unique case (stateR)
      ST_IDLE:   if (strobe.capture) stateNext = ST_FIRST;
      ST_FIRST:  if (tagReady) stateNext = ST_SECOND;
      ST_SECOND: if (tagReady) stateNext = wbPending ? ST_WB : ST_IDLE;
      ST_WB:     stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      undefR <= 1'b0;
      alignR <= 1'b0;
    end else begin
      stateR <= stateNext;
      undefR <= accept && !legal;
      alignR <= accept && legal && spMisaligned;
    end
  end

  assign instrReady = (stateR == ST_IDLE);
  assign tagValid   = (stateR == ST_FIRST) || (stateR == ST_SECOND);
  assign wbValid    = (stateR == ST_WB);
  assign undefFlag  = undefR;
  assign alignFault = alignR;

endmodule

// File: rtl/tagpair_dp.sv
module tagpair_dp #(
  parameter int ADDR_W       = 64,
  parameter int GRANULE_LOG2 = 4,
  parameter int TAG_W        = 4,
  parameter int REG_IDX_W    = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tagpair_pkg::dpStrobe_t strobe,
  input  logic [ADDR_W-1:0]      baseData,
  input  logic [TAG_W-1:0]       tagBits,
  input  logic [ADDR_W-1:0]      offset,
  input  logic                   writeBack,
  input  logic                   postIndex,
  input  logic [REG_IDX_W-1:0]   baseIdx,
  output logic                   spMisaligned,
  output logic                   wbPending,
  output logic [ADDR_W-1:0]      tagAddr,
  output logic [TAG_W-1:0]       tagData,
  output logic [ADDR_W-1:0]      wbData,
  output logic [REG_IDX_W-1:0]   wbIdx
);
  localparam logic [REG_IDX_W-1:0] SP_IDX  = '1;
  localparam logic [ADDR_W-1:0]    GRANULE = ADDR_W'(1) << GRANULE_LOG2;

  logic [ADDR_W-1:0]    offsetSum;
  logic [ADDR_W-1:0]    firstAddrR, wbAddrR;
  logic [TAG_W-1:0]     tagR;
  logic [REG_IDX_W-1:0] wbIdxR;
  logic                 wbPendR;

  assign offsetSum    = baseData + offset;
  assign spMisaligned = (baseIdx == SP_IDX) && (|baseData[GRANULE_LOG2-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstAddrR <= '0;
      wbAddrR    <= '0;
      tagR       <= '0;
      wbIdxR     <= '0;
      wbPendR    <= 1'b0;
    end else if (strobe.capture) begin
      firstAddrR <= postIndex ? baseData : offsetSum;
      wbAddrR    <= offsetSum;
      tagR       <= tagBits;
      wbIdxR     <= baseIdx;
      wbPendR    <= writeBack;
    end
  end

  assign tagAddr   = strobe.useSecond ? (firstAddrR + GRANULE) : firstAddrR;
  assign tagData   = tagR;
  assign wbData    = wbAddrR;
  assign wbIdx     = wbIdxR;
  assign wbPending = wbPendR;

endmodule

// File: rtl/tagpair_store.sv
module tagpair_store #(
  parameter int ADDR_W       = 64,
  parameter int GRANULE_LOG2 = 4,
  parameter int TAG_W        = 4,
  parameter int TAG_LSB      = 56,
  parameter int REG_IDX_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 featureEn,
  input  logic                 instrValid,
  input  logic [31:0]          instrWord,
  output logic                 instrReady,
  output logic [REG_IDX_W-1:0] rfBaseIdx,
  input  logic [ADDR_W-1:0]    rfBaseData,
  output logic [REG_IDX_W-1:0] rfSrcIdx,
  input  logic [ADDR_W-1:0]    rfSrcData,
  output logic                 tagValid,
  input  logic                 tagReady,
  output logic [ADDR_W-1:0]    tagAddr,
  output logic [TAG_W-1:0]     tagData,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbIdx,
  output logic [ADDR_W-1:0]    wbData,
  output logic                 undefFlag,
  output logic                 alignFault
);
  import tagpair_pkg::*;

  logic                 legal, writeBack, postIndex, spMisaligned, wbPending;
  logic [REG_IDX_W-1:0] baseIdx, srcIdx;
  logic [ADDR_W-1:0]    offset;
  dpStrobe_t            strobe;

  tagpair_decode #(
    .ADDR_W(ADDR_W), .GRANULE_LOG2(GRANULE_LOG2), .REG_IDX_W(REG_IDX_W)
  ) u_decode (
    .instrWord(instrWord), .featureEn(featureEn), .legal(legal),
    .writeBack(writeBack), .postIndex(postIndex), .baseIdx(baseIdx),
    .srcIdx(srcIdx), .offset(offset)
  );

  tagpair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .legal(legal),
    .spMisaligned(spMisaligned), .wbPending(wbPending), .tagReady(tagReady),
    .instrReady(instrReady), .tagValid(tagValid), .wbValid(wbValid),
    .undefFlag(undefFlag), .alignFault(alignFault), .strobe(strobe)
  );

  tagpair_dp #(
    .ADDR_W(ADDR_W), .GRANULE_LOG2(GRANULE_LOG2), .TAG_W(TAG_W),
    .REG_IDX_W(REG_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseData(rfBaseData),
    .tagBits(rfSrcData[TAG_LSB +: TAG_W]), .offset(offset),
    .writeBack(writeBack), .postIndex(postIndex), .baseIdx(baseIdx),
    .spMisaligned(spMisaligned), .wbPending(wbPending), .tagAddr(tagAddr),
    .tagData(tagData), .wbData(wbData), .wbIdx(wbIdx)
  );

  assign rfBaseIdx = baseIdx;
  assign rfSrcIdx  = srcIdx;

endmodule

// File: rtl/tagpair_store_chk.sv
module tagpair_store_chk #(
  parameter int ADDR_W       = 64,
  parameter int GRANULE_LOG2 = 4,
  parameter int TAG_W        = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic              instrReady,
  input logic              tagValid,
  input logic              tagReady,
  input logic [ADDR_W-1:0] tagAddr,
  input logic [TAG_W-1:0]  tagData,
  input logic              wbValid,
  input logic              undefFlag,
  input logic              alignFault
);
  localparam logic [ADDR_W-1:0] GRANULE = ADDR_W'(1) << GRANULE_LOG2;

  logic              beatR;
  logic [ADDR_W-1:0] firstAddrR;
  logic [TAG_W-1:0]  firstTagR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatR      <= 1'b0;
      firstAddrR <= '0;
      firstTagR  <= '0;
    end else if (instrValid && instrReady) begin
      beatR <= 1'b0;
    end else if (tagValid && tagReady) begin
      beatR      <= !beatR;
      firstAddrR <= tagAddr;
      firstTagR  <= tagData;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagReady) |=> (tagValid && $stable(tagAddr) && $stable(tagData)));

  p_second_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && beatR) |-> (tagAddr == firstAddrR + GRANULE));

  p_same_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && beatR) |-> (tagData == firstTagR));

  p_wb_after_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(tagValid && tagReady && beatR));

  p_wb_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    instrReady |-> (!tagValid && !wbValid));

  p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> (!tagValid && !wbValid && !alignFault));

  p_align_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!tagValid && !wbValid));

endmodule

bind tagpair_store tagpair_store_chk #(
  .ADDR_W(ADDR_W), .GRANULE_LOG2(GRANULE_LOG2), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
  .tagValid(tagValid), .tagReady(tagReady), .tagAddr(tagAddr),
  .tagData(tagData), .wbValid(wbValid), .undefFlag(undefFlag),
  .alignFault(alignFault)
);

// File: tb/tagpair_store_tb.sv
module tagpair_store_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        featureEn = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        instrReady;
  logic [4:0]  rfBaseIdx, rfSrcIdx, wbIdx;
  logic [63:0] rfBaseData, rfSrcData, tagAddr, wbData;
  logic        tagValid, wbValid, undefFlag, alignFault;
  logic        tagReady = 1'b0;
  logic [3:0]  tagData;

  logic [63:0] regFile [32];
  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;

  assign rfBaseData = regFile[rfBaseIdx];
  assign rfSrcData  = regFile[rfSrcIdx];

  always #5 clk = ~clk;

  tagpair_store u_dut (
    .clk(clk), .rstN(rstN), .featureEn(featureEn), .instrValid(instrValid),
    .instrWord(instrWord), .instrReady(instrReady), .rfBaseIdx(rfBaseIdx),
    .rfBaseData(rfBaseData), .rfSrcIdx(rfSrcIdx), .rfSrcData(rfSrcData),
    .tagValid(tagValid), .tagReady(tagReady), .tagAddr(tagAddr),
    .tagData(tagData), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .undefFlag(undefFlag), .alignFault(alignFault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [8:0] imm, input logic [1:0] form,
                                         input logic [4:0] rn, input logic [4:0] rt);
    return {8'hD9, 2'b10, 1'b1, imm, form, rn, rt};
  endfunction

  function automatic logic [63:0] expOffset(input logic [8:0] imm);
    return {{55{imm[8]}}, imm} << 4;
  endfunction

  task automatic runOp(input logic [31:0] word, input logic fe);
    logic        legalE, alignE, wbE;
    logic [63:0] base, addr1, sumE;
    logic [3:0]  tagE;
    logic [4:0]  rn;
    int beats = 0;
    int wbCount = 0;
    int undefCount = 0;
    int alignCount = 0;
    int lastBeatCyc = -1;
    int wbCyc = -1;
    logic [63:0] beatAddr [2];
    logic [3:0]  beatTag [2];
    logic [4:0]  gotWbIdx = '0;
    logic [63:0] gotWbData = '0;
    int cyc = 0;
    rn     = word[9:5];
    base   = regFile[rn];
    legalE = fe && word[31:21] == 11'b11011001_10_1 && word[11:10] != 2'b00;
    alignE = legalE && rn == 5'd31 && base[3:0] != 4'h0;
    sumE   = base + expOffset(word[20:12]);
    addr1  = (word[11:10] == 2'b01) ? base : sumE;
    tagE   = regFile[word[4:0]][59:56];
    wbE    = legalE && !alignE && word[10];
    beatAddr[0] = '0; beatAddr[1] = '0; beatTag[0] = '0; beatTag[1] = '0;

    @(negedge clk);
    chk("R10 ready before issue", {63'd0, instrReady}, 64'd1);
    featureEn  = fe;
    instrWord  = word;
    instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    forever begin
      if (undefFlag) undefCount++;
      if (alignFault) alignCount++;
      if (wbValid) begin
        wbCount++; wbCyc = cyc; gotWbIdx = wbIdx; gotWbData = wbData;
      end
      if (tagValid) begin
        tagReady = ($urandom % 3) != 0;
        if (tagReady) begin
          if (beats < 2) begin
            beatAddr[beats] = tagAddr;
            beatTag[beats] = tagData;
          end
          beats++;
          lastBeatCyc = cyc;
        end
      end else begin
        tagReady = 1'b0;
      end
      if (instrReady || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    tagReady = 1'b0;
    chk("R9 op finished", {63'd0, instrReady}, 64'd1);

    if (!legalE) begin
      chk(fe ? "R1 undef flag" : "R2 undef when disabled", 64'(undefCount), 64'd1);
      chk(fe ? "R1 no tag writes" : "R2 no tag writes", 64'(beats), 64'd0);
      chk(fe ? "R1 no writeback" : "R2 no writeback", 64'(wbCount), 64'd0);
    end else if (alignE) begin
      chk("R7 align fault", 64'(alignCount), 64'd1);
      chk("R7 no tag writes", 64'(beats), 64'd0);
      chk("R7 no writeback", 64'(wbCount), 64'd0);
    end else begin
      chk("R1 no undef on legal", 64'(undefCount), 64'd0);
      chk("R7 no align fault", 64'(alignCount), 64'd0);
      chk("R9 two beats", 64'(beats), 64'd2);
      chk("R4 first addr", beatAddr[0], addr1);
      chk("R3 R5 second addr", beatAddr[1], addr1 + 64'd16);
      chk("R6 tag first", 64'(beatTag[0]), 64'(tagE));
      chk("R5 tag second", 64'(beatTag[1]), 64'(tagE));
      chk("R8 writeback count", 64'(wbCount), wbE ? 64'd1 : 64'd0);
      if (wbE) begin
        chk("R8 wb after pair", 64'(wbCyc > lastBeatCyc), 64'd1);
        chk("R8 wb index", 64'(gotWbIdx), 64'(rn));
        chk("R8 wb data", gotWbData, sumE);
      end
    end
  endtask

  task automatic fillRegs();
    for (int i = 0; i < 32; i++) regFile[i] = {$urandom, $urandom};
    if (($urandom % 4) != 0) regFile[31][3:0] = 4'h0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCnt++;
      if (cycleCnt > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R10 act=%0d exp=done", cycleCnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) regFile[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset ready", {63'd0, instrReady}, 64'd1);
    chk("R10 reset tagValid", {63'd0, tagValid}, 64'd0);
    chk("R10 reset wbValid", {63'd0, wbValid}, 64'd0);
    chk("R10 reset flags", {62'd0, undefFlag, alignFault}, 64'd0);
    rstN = 1'b1;

    // Directed corners
    fillRegs();
    regFile[3] = 64'h0000_0000_0001_0000;
    regFile[4] = 64'h0A00_0000_0000_0000;
    runOp(mkWord(9'h100, 2'b10, 5'd3, 5'd4), 1'b1);   // R3 most negative
    runOp(mkWord(9'h0FF, 2'b11, 5'd3, 5'd4), 1'b1);   // R3 most positive, pre-index
    runOp(mkWord(9'h0FF, 2'b01, 5'd3, 5'd4), 1'b1);   // R4 post-index
    regFile[7] = 64'hFFFF_FFFF_FFFF_FFF0;
    runOp(mkWord(9'h001, 2'b11, 5'd7, 5'd4), 1'b1);   // address wrap
    regFile[31] = 64'h5F00_0000_0000_1230;
    runOp(mkWord(9'h1FF, 2'b11, 5'd31, 5'd31), 1'b1); // R6 SP as base and source
    regFile[31] = 64'h0000_0000_0000_1238;
    runOp(mkWord(9'h002, 2'b10, 5'd31, 5'd2), 1'b1);  // R7 misaligned SP
    runOp(mkWord(9'h002, 2'b00, 5'd3, 5'd2), 1'b1);   // R1 form 00
    runOp(mkWord(9'h002, 2'b11, 5'd3, 5'd2), 1'b0);   // R2 feature off
    runOp(mkWord(9'h002, 2'b11, 5'd3, 5'd2) ^ 32'h0040_0000, 1'b1); // R1 bad opc

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [1:0]  form;
      fillRegs();
      form = ($urandom % 8 == 0) ? 2'b00 : 2'(1 + ($urandom % 3));
      w = mkWord(9'($urandom), form, 5'(($urandom % 4 == 0) ? 31 : $urandom), 5'($urandom));
      if ($urandom % 10 == 0) w[21 + ($urandom % 11)] ^= 1'b1;
      runOp(w, ($urandom % 12) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule